// File: doc/BRIEF.md
# Register Pair File with Stack Sequencer

This block holds the programmer-visible 16-bit state of a small 8-bit processor. That state is three general register pairs (BC, DE, HL), an accumulator/flag pair (AF, accumulator in the high byte), a stack pointer and a program counter. It carries out the operations that act on whole pairs: immediate loads, 16-bit increment and decrement, a 16-bit add into HL, the exchange and copy operations, and the stack sequences. The stack sequences are push, pop, call, return, restart and exchange-with-top-of-stack. They move one byte per transfer over a byte-wide memory port that uses a request/acknowledge handshake.

A command is a 4-bit operation code, a 2-bit pair select and a 16-bit immediate. The command is presented with `cmd_valid`. Single-cycle operations take effect at the next clock edge. Stack operations raise `busy` from the following cycle until their last byte is acknowledged. Commands offered while `busy` is high are dropped. The program counter is assumed to already hold the address of the next instruction when a call or restart is issued.

Top module: `rpf_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC, SP and all four pairs become 0000h and `busy`/`mem_req` are low.
- R2: Op code 1 loads `cmd_imm` into the selected pair. Pair select 0=BC, 1=DE, 2=HL, 3=SP for this op and for codes 2, 3 and 4.
- R3: Op code 2 (increment) and op code 3 (decrement) treat the selected pair as one 16-bit number that wraps modulo 65536, and leave AF unchanged.
- R4: Op code 4 adds the selected pair into HL. Bit 0 of the flag byte (AF bit 0) becomes the carry out of bit 15. All other AF bits are kept.
- R5: Op code 5 swaps DE with HL.
- R6: Op code 6 copies HL into SP and op code 7 copies HL into PC, with H as the high byte.
- R7: Op code 8 (push, pair select 3 = AF) writes the high byte at SP−1, then the low byte at SP−2, and leaves SP reduced by 2.
- R8: Op code 9 (pop, pair select 3 = AF) reads the low byte from SP, then the high byte from SP+1, and leaves SP raised by 2.
- R9: Op code 10 (call) pushes PC in the R7 order and then loads PC with `cmd_imm`. Op code 11 (return) pops two bytes into PC in the R8 order.
- R10: Op code 12 (restart) pushes PC in the R7 order and then loads PC with `cmd_imm[2:0]`×8.
- R11: Op code 13 reads SP, writes L at SP, reads SP+1 and writes H at SP+1, in that order. L and H end up holding the bytes that were read, and SP is unchanged.
- R12: `busy` is high from the cycle after a stack command is accepted until the cycle after its final acknowledge. Commands offered while busy, and op codes 0, 14 and 15, have no effect.
- R13: A request holds its address, direction and write data until `mem_ack`. Exactly one byte moves per acknowledged cycle, and the read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_pair | input | 2 | Pair select |
| cmd_imm | input | 16 | Immediate value, call target or restart index |
| busy | output | 1 | Stack sequence in progress |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| bc_out | output | 16 | BC pair |
| de_out | output | 16 | DE pair |
| hl_out | output | 16 | HL pair |
| af_out | output | 16 | Accumulator (high) and flags (low) |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |

## Verification
The bench targets the byte order of each stack sequence: a push that wrote the low byte first, or at SP instead of SP−1, shows up as a wrong address or wrong data on the bus. It drives the stack pointer across the 0000h/FFFFh boundary, where a design that mishandles wrap writes to the wrong page. It also runs exchange-with-top-of-stack under stretched acknowledges. A design that wrote before reading, or moved SP, would return stale bytes in L and H. Random commands are fired while `busy` is high, so a design that let them through would corrupt a pair. A 16-bit add that touched flag bits other than bit 0 shows up because AF is first loaded with a dense pattern.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WORD_W    = 2 * BYTE_W;
    localparam int unsigned NPAIR     = 4;
    localparam int unsigned CARRY_BIT = 0;
    localparam int unsigned RST_SHIFT = 3;
    localparam int unsigned RST_IDX_W = 3;
    localparam int unsigned STEP_W    = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDI   = 4'd1,
        OP_INC   = 4'd2,
        OP_DEC   = 4'd3,
        OP_ADDHL = 4'd4,
        OP_XCHG  = 4'd5,
        OP_SPHL  = 4'd6,
        OP_PCHL  = 4'd7,
        OP_PUSH  = 4'd8,
        OP_POP   = 4'd9,
        OP_CALL  = 4'd10,
        OP_RET   = 4'd11,
        OP_RST   = 4'd12,
        OP_XTOP  = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        PR_BC = 2'd0,
        PR_DE = 2'd1,
        PR_HL = 2'd2,
        PR_X  = 2'd3
    } pair_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_LO,
        DST_HI,
        DST_PC_LO,
        DST_PC_HI
    } dst_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_INC,
        SP_DEC
    } spmv_e;

    typedef struct packed {
        dst_e  dst;
        pair_e pair;
        byte_t data;
        spmv_e spmv;
        logic  pc_ld;
        word_t pc_val;
    } wb_t;

    function automatic byte_t hi_of(word_t w);
        return w[WORD_W-1:BYTE_W];
    endfunction

    function automatic byte_t lo_of(word_t w);
        return w[BYTE_W-1:0];
    endfunction

    function automatic logic is_multi(op_e op);
        return op inside {OP_PUSH, OP_POP, OP_CALL, OP_RET, OP_RST, OP_XTOP};
    endfunction

endpackage

// File: rtl/rpf_pair_alu.sv
module rpf_pair_alu
    import rpf_pkg::*;
(
    input  op_e   op_i,
    input  word_t a_i,
    input  word_t hl_i,
    output word_t res_o,
    output logic  carry_o
);

    logic [WORD_W:0] sum;

    always_comb begin
        sum     = {1'b0, hl_i} + {1'b0, a_i};
        carry_o = sum[WORD_W];
        case (op_i)
            OP_INC:   res_o = a_i + word_t'(1);
            OP_DEC:   res_o = a_i - word_t'(1);
            OP_ADDHL: res_o = sum[WORD_W-1:0];
            default:  res_o = a_i;
        endcase
    end

endmodule

// File: rtl/rpf_stack_seq.sv
module rpf_stack_seq
    import rpf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  op_e   op_i,
    input  pair_e pair_i,
    input  word_t push_i,
    input  word_t pc_i,
    input  word_t hl_i,
    input  word_t sp_i,
    input  word_t tgt_i,
    input  logic  mem_ack_i,
    input  byte_t mem_rdata_i,
    output logic  busy_o,
    output logic  mem_req_o,
    output logic  mem_we_o,
    output word_t mem_addr_o,
    output byte_t mem_wdata_o,
    output logic  wb_fire_o,
    output wb_t   wb_o
);

    typedef enum logic {SQ_IDLE, SQ_RUN} sq_e;

    sq_e               st_q;
    logic [STEP_W-1:0] step_q;
    op_e               op_q;
    pair_e             pair_q;
    word_t             val_q;
    word_t             tgt_q;
    byte_t             tmp_q;

    logic push_kind, pop_kind, last;

    assign push_kind = op_q inside {OP_PUSH, OP_CALL, OP_RST};
    assign pop_kind  = op_q inside {OP_POP, OP_RET};
    assign busy_o    = (st_q == SQ_RUN);
    assign mem_req_o = (st_q == SQ_RUN);
    assign wb_fire_o = (st_q == SQ_RUN) && mem_ack_i;

    always_comb begin
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_i;
        mem_wdata_o = '0;
        last        = 1'b0;
        wb_o        = '{dst: DST_NONE, pair: pair_q, data: mem_rdata_i,
                        spmv: SP_HOLD, pc_ld: 1'b0, pc_val: tgt_q};
        if (push_kind) begin
            // pre-decrement: every byte lands one below the current SP
            mem_addr_o  = sp_i - word_t'(1);
            mem_we_o    = 1'b1;
            mem_wdata_o = step_q[0] ? lo_of(val_q) : hi_of(val_q);
            last        = (step_q == STEP_W'(1));
            wb_o.spmv   = SP_DEC;
            wb_o.pc_ld  = last && (op_q != OP_PUSH);
        end else if (pop_kind) begin
            // post-increment: read at SP, then move up
            mem_addr_o = sp_i;
            last       = (step_q == STEP_W'(1));
            wb_o.spmv  = SP_INC;
            if (op_q == OP_RET)
                wb_o.dst = step_q[0] ? DST_PC_HI : DST_PC_LO;
            else
                wb_o.dst = step_q[0] ? DST_HI : DST_LO;
        end else begin
            // exchange with top of stack: read, write, read, write
            mem_addr_o  = step_q[1] ? sp_i + word_t'(1) : sp_i;
            mem_we_o    = step_q[0];
            mem_wdata_o = step_q[1] ? hi_of(val_q) : lo_of(val_q);
            last        = (step_q == STEP_W'(3));
            wb_o.pair   = PR_HL;
            wb_o.data   = tmp_q;
            if (step_q[0])
                wb_o.dst = step_q[1] ? DST_HI : DST_LO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            step_q <= '0;
            op_q   <= OP_NOP;
            pair_q <= PR_BC;
            val_q  <= '0;
            tgt_q  <= '0;
            tmp_q  <= '0;
        end else if (st_q == SQ_IDLE) begin
            if (start_i) begin
                st_q   <= SQ_RUN;
                step_q <= '0;
                op_q   <= op_i;
                pair_q <= pair_i;
                if (op_i == OP_CALL || op_i == OP_RST)
                    val_q <= pc_i;
                else if (op_i == OP_XTOP)
                    val_q <= hl_i;
                else
                    val_q <= push_i;
                if (op_i == OP_RST)
                    tgt_q <= word_t'(tgt_i[RST_IDX_W-1:0]) << RST_SHIFT;
                else
                    tgt_q <= tgt_i;
            end
        end else if (mem_ack_i) begin
            if (!mem_we_o)
                tmp_q <= mem_rdata_i;
            step_q <= step_q + STEP_W'(1);
            if (last)
                st_q <= SQ_IDLE;
        end
    end

    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    a_r7_push_sp_dec: assert property (@(posedge clk) disable iff (rst)
        (wb_fire_o && mem_we_o && push_kind) |=> (sp_i == word_t'($past(sp_i) - word_t'(1))));

    a_r8_pop_sp_inc: assert property (@(posedge clk) disable iff (rst)
        (wb_fire_o && pop_kind) |=> (sp_i == word_t'($past(sp_i) + word_t'(1))));

    a_r11_xtop_sp_kept: assert property (@(posedge clk) disable iff (rst)
        (busy_o && op_q == OP_XTOP) |=> $stable(sp_i));

endmodule

// File: rtl/rpf_core.sv
module rpf_core
    import rpf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [3:0]          cmd_op,
    input  logic [1:0]          cmd_pair,
    input  logic [WORD_W-1:0]   cmd_imm,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [WORD_W-1:0]   bc_out,
    output logic [WORD_W-1:0]   de_out,
    output logic [WORD_W-1:0]   hl_out,
    output logic [WORD_W-1:0]   af_out,
    output logic [WORD_W-1:0]   sp_out,
    output logic [WORD_W-1:0]   pc_out
);

    op_e   op;
    pair_e pair;
    word_t pr_q [NPAIR];
    word_t sp_q, pc_q;
    word_t alu_a, alu_res;
    logic  alu_c;
    logic  accept, start, wb_fire;
    wb_t   wb;

    assign op     = op_e'(cmd_op);
    assign pair   = pair_e'(cmd_pair);
    assign accept = cmd_valid && !busy;
    assign start  = accept && is_multi(op);
    assign alu_a  = (pair == PR_X) ? sp_q : pr_q[pair];

    rpf_pair_alu u_alu (
        .op_i    (op),
        .a_i     (alu_a),
        .hl_i    (pr_q[PR_HL]),
        .res_o   (alu_res),
        .carry_o (alu_c)
    );

    rpf_stack_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .op_i        (op),
        .pair_i      (pair),
        .push_i      (pr_q[pair]),
        .pc_i        (pc_q),
        .hl_i        (pr_q[PR_HL]),
        .sp_i        (sp_q),
        .tgt_i       (cmd_imm),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .busy_o      (busy),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .wb_fire_o   (wb_fire),
        .wb_o        (wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPAIR; i++)
                pr_q[i] <= '0;
            sp_q <= '0;
            pc_q <= '0;
        end else if (wb_fire) begin
            case (wb.dst)
                DST_LO:    pr_q[wb.pair][BYTE_W-1:0]      <= wb.data;
                DST_HI:    pr_q[wb.pair][WORD_W-1:BYTE_W] <= wb.data;
                DST_PC_LO: pc_q[BYTE_W-1:0]               <= wb.data;
                DST_PC_HI: pc_q[WORD_W-1:BYTE_W]          <= wb.data;
                default:   ;
            endcase
            case (wb.spmv)
                SP_INC:  sp_q <= sp_q + word_t'(1);
                SP_DEC:  sp_q <= sp_q - word_t'(1);
                default: ;
            endcase
            if (wb.pc_ld)
                pc_q <= wb.pc_val;
        end else if (accept) begin
            case (op)
                OP_LDI: begin
                    if (pair == PR_X) sp_q <= cmd_imm;
                    else              pr_q[pair] <= cmd_imm;
                end
                OP_INC, OP_DEC: begin
                    if (pair == PR_X) sp_q <= alu_res;
                    else              pr_q[pair] <= alu_res;
                end
                OP_ADDHL: begin
                    pr_q[PR_HL]            <= alu_res;
                    pr_q[PR_X][CARRY_BIT]  <= alu_c;
                end
                OP_XCHG: begin
                    pr_q[PR_DE] <= pr_q[PR_HL];
                    pr_q[PR_HL] <= pr_q[PR_DE];
                end
                OP_SPHL: sp_q <= pr_q[PR_HL];
                OP_PCHL: pc_q <= pr_q[PR_HL];
                default: ;
            endcase
        end
    end

    assign bc_out = pr_q[PR_BC];
    assign de_out = pr_q[PR_DE];
    assign hl_out = pr_q[PR_HL];
    assign af_out = pr_q[PR_X];
    assign sp_out = sp_q;
    assign pc_out = pc_q;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && sp_q == '0 && !busy && !mem_req));

    a_r12_busy_freeze: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ack) |=> ($stable(bc_out) && $stable(de_out) && $stable(hl_out)
                                && $stable(af_out) && $stable(sp_out) && $stable(pc_out)));

    a_r3_no_flag_change: assert property (@(posedge clk) disable iff (rst)
        (accept && op inside {OP_INC, OP_DEC, OP_LDI, OP_XCHG, OP_SPHL, OP_PCHL})
        |=> $stable(af_out));

    a_r4_only_carry: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_ADDHL) |=> (af_out[WORD_W-1:1] == $past(af_out[WORD_W-1:1])));

endmodule

// File: tb/sim_rpf_core.sv
module sim_rpf_core;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, cmd_valid, busy, mem_req, mem_we, mem_ack;
    logic [3:0]  cmd_op;
    logic [1:0]  cmd_pair;
    logic [15:0] cmd_imm, mem_addr, bc, de, hl, af, sp, pc;
    logic [7:0]  mem_wdata, mem_rdata;

    rpf_core u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pair(cmd_pair), .cmd_imm(cmd_imm), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .bc_out(bc), .de_out(de),
        .hl_out(hl), .af_out(af), .sp_out(sp), .pc_out(pc)
    );

    int  n_vec = 0, n_bad = 0, ack_pct = 100;
    bit  done = 0;
    logic [7:0]  mem [0:65535];
    logic [15:0] m_pr [4], p_pr [4];
    logic [15:0] m_sp, m_pc, p_sp, p_pc;
    logic [15:0] q_addr [$];
    bit          q_we   [$];
    logic [7:0]  q_wd   [$];
    string       cur_tag = "R1", last_tag = "R1";

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bool_busy: begin
            chk("R12", "busy", {15'd0, busy}, {15'd0, q_addr.size() != 0});
        end
        if (q_addr.size() != 0) begin
            chk({cur_tag, "/R13"}, "mem_req", {15'd0, mem_req}, 16'd1);
            chk(cur_tag, "mem_addr", mem_addr, q_addr[0]);
            chk(cur_tag, "mem_we", {15'd0, mem_we}, {15'd0, q_we[0]});
            if (q_we[0]) chk(cur_tag, "mem_wdata", {8'd0, mem_wdata}, {8'd0, q_wd[0]});
        end else begin
            chk("R13", "mem_req idle", {15'd0, mem_req}, 16'd0);
            chk(last_tag, "BC", bc, m_pr[0]);
            chk(last_tag, "DE", de, m_pr[1]);
            chk(last_tag, "HL", hl, m_pr[2]);
            chk(last_tag, "AF", af, m_pr[3]);
            chk(last_tag, "SP", sp, m_sp);
            chk(last_tag, "PC", pc, m_pc);
        end
    endtask

    task automatic enq(logic [15:0] a, bit w, logic [7:0] d);
        q_addr.push_back(a);
        q_we.push_back(w);
        q_wd.push_back(d);
    endtask

    task automatic model_cmd(logic [3:0] op, logic [1:0] pr, logic [15:0] imm);
        logic [16:0] s;
        logic [15:0] a, src, t;
        a = (pr == 2'd3) ? m_sp : m_pr[pr];
        p_pr = m_pr; p_sp = m_sp; p_pc = m_pc;
        case (op)
            4'd1: begin if (pr == 2'd3) m_sp = imm; else m_pr[pr] = imm; last_tag = "R2"; end
            4'd2: begin if (pr == 2'd3) m_sp = a + 16'd1; else m_pr[pr] = a + 16'd1; last_tag = "R3"; end
            4'd3: begin if (pr == 2'd3) m_sp = a - 16'd1; else m_pr[pr] = a - 16'd1; last_tag = "R3"; end
            4'd4: begin
                s = {1'b0, m_pr[2]} + {1'b0, a};
                m_pr[2] = s[15:0];
                m_pr[3][0] = s[16];
                last_tag = "R4";
            end
            4'd5: begin t = m_pr[1]; m_pr[1] = m_pr[2]; m_pr[2] = t; last_tag = "R5"; end
            4'd6: begin m_sp = m_pr[2]; last_tag = "R6"; end
            4'd7: begin m_pc = m_pr[2]; last_tag = "R6"; end
            4'd8, 4'd10, 4'd12: begin
                src = (op == 4'd8) ? m_pr[pr] : m_pc;
                enq(m_sp - 16'd1, 1'b1, src[15:8]);
                enq(m_sp - 16'd2, 1'b1, src[7:0]);
                p_sp = m_sp - 16'd2;
                if (op == 4'd10) p_pc = imm;
                if (op == 4'd12) p_pc = {10'd0, imm[2:0], 3'd0};
                cur_tag = (op == 4'd8) ? "R7" : (op == 4'd10) ? "R9" : "R10";
            end
            4'd9, 4'd11: begin
                t = m_sp + 16'd1;
                enq(m_sp, 1'b0, 8'h00);
                enq(t, 1'b0, 8'h00);
                p_sp = m_sp + 16'd2;
                if (op == 4'd9) p_pr[pr] = {mem[t], mem[m_sp]};
                else            p_pc = {mem[t], mem[m_sp]};
                cur_tag = (op == 4'd9) ? "R8" : "R9";
            end
            4'd13: begin
                t = m_sp + 16'd1;
                enq(m_sp, 1'b0, 8'h00);
                enq(m_sp, 1'b1, m_pr[2][7:0]);
                enq(t, 1'b0, 8'h00);
                enq(t, 1'b1, m_pr[2][15:8]);
                p_pr[2] = {mem[t], mem[m_sp]};
                cur_tag = "R11";
            end
            default: last_tag = "R12";
        endcase
    endtask

    task automatic cycle(bit v, logic [3:0] op, logic [1:0] pr, logic [15:0] imm);
        bit ack;
        compare();
        ack = 1'b0;
        mem_rdata = 8'h00;
        if (q_addr.size() != 0) begin
            ack = ($urandom_range(99) < ack_pct);
            if (ack) begin
                if (q_we[0]) mem[q_addr[0]] = q_wd[0];
                else         mem_rdata = mem[q_addr[0]];
            end
        end
        mem_ack   = ack;
        cmd_valid = v;
        cmd_op    = op;
        cmd_pair  = pr;
        cmd_imm   = imm;
        if (q_addr.size() != 0) begin
            if (ack) begin
                void'(q_addr.pop_front());
                void'(q_we.pop_front());
                void'(q_wd.pop_front());
                if (q_addr.size() == 0) begin
                    m_pr = p_pr; m_sp = p_sp; m_pc = p_pc;
                    last_tag = cur_tag;
                end
            end
        end else if (v) begin
            model_cmd(op, pr, imm);
        end
        @(negedge clk);
    endtask

    // one command, then random traffic (ignored, R12) until the sequence ends
    task automatic issue(logic [3:0] op, logic [1:0] pr, logic [15:0] imm);
        cycle(1'b1, op, pr, imm);
        while (q_addr.size() != 0)
            cycle(1'($urandom_range(1)), 4'($urandom_range(15)),
                  2'($urandom_range(3)), 16'($urandom));
    endtask

    initial begin
        for (int i = 0; i < 65536; i++)
            mem[i] = 8'((i * 37) ^ (i >> 8) ^ 8'h5A);
        for (int i = 0; i < 4; i++) m_pr[i] = 16'h0000;
        m_sp = 16'h0000; m_pc = 16'h0000;
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_pair = 2'd0;
        cmd_imm = 16'h0000; mem_ack = 1'b0; mem_rdata = 8'h00;
        repeat (3) @(negedge clk);
        compare();                         // R1 reset state
        rst = 1'b0;
        last_tag = "R2";
        issue(4'd1, 2'd0, 16'h1234);       // R2 loads
        issue(4'd1, 2'd1, 16'hABCD);
        issue(4'd1, 2'd2, 16'hFFFF);
        issue(4'd1, 2'd3, 16'h4000);
        issue(4'd2, 2'd2, 16'h0000);       // R3 increment wraps to 0000
        issue(4'd3, 2'd0, 16'h0000);       // R3 decrement
        issue(4'd3, 2'd3, 16'h0000);       // R3 SP
        issue(4'd2, 2'd3, 16'h0000);
        issue(4'd9, 2'd3, 16'h0000);       // R8 pop into AF: dense flag byte
        issue(4'd1, 2'd2, 16'hFFFF);
        issue(4'd4, 2'd1, 16'h0000);       // R4 carry out set
        issue(4'd4, 2'd0, 16'h0000);       // R4 carry cleared
        issue(4'd4, 2'd2, 16'h0000);       // R4 HL+HL
        issue(4'd5, 2'd0, 16'h0000);       // R5
        issue(4'd8, 2'd0, 16'h0000);       // R7 push BC
        issue(4'd8, 2'd3, 16'h0000);       // R7 push AF
        issue(4'd9, 2'd1, 16'h0000);       // R8 pop DE
        issue(4'd13, 2'd0, 16'h0000);      // R11
        issue(4'd1, 2'd3, 16'h0001);       // SP near wrap
        issue(4'd8, 2'd0, 16'h0000);       // R7 writes 0000h then FFFFh
        issue(4'd9, 2'd2, 16'h0000);       // R8 reads back across wrap
        issue(4'd1, 2'd3, 16'hFFFF);
        issue(4'd13, 2'd0, 16'h0000);      // R11 with SP+1 wrapping
        issue(4'd10, 2'd0, 16'h5678);      // R9 call
        issue(4'd11, 2'd0, 16'h0000);      // R9 return
        issue(4'd12, 2'd0, 16'hFFF5);      // R10 restart index 5
        issue(4'd6, 2'd0, 16'h0000);       // R6 SP from HL
        issue(4'd7, 2'd0, 16'h0000);       // R6 PC from HL
        issue(4'd0, 2'd1, 16'h1111);       // R12 unused codes
        issue(4'd14, 2'd2, 16'h2222);
        issue(4'd15, 2'd3, 16'h3333);
        ack_pct = 35;
        issue(4'd13, 2'd0, 16'h0000);      // R11 with stretched acks
        issue(4'd8, 2'd3, 16'h0000);       // R13 stretched push
        for (int k = 0; k < 3000; k++)
            issue(4'($urandom_range(15)), 2'($urandom_range(3)), 16'($urandom));
        cycle(1'b0, 4'd0, 2'd0, 16'h0000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual busy-hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule